// File: doc/BRIEF.md
# Predicate-Driven Byte Expand Unit

This block spreads a densely packed stream of bytes out to the byte lanes chosen by a predicate. It takes a 64-lane source vector and a 64-bit predicate with one bit per lane. Each result lane whose predicate bit is set takes the next byte from the source stream. That byte's position in the stream is the number of set predicate bits in the lanes below it. Every result lane whose predicate bit is clear takes the fill byte, which is source lane 63.

The unit is a two-stage pipeline. Stage one takes the exclusive prefix population count of the predicate with a parallel-prefix adder tree. Stage two forms each lane's clamped read index and drives a per-lane byte multiplexer. A new operand pair may be offered on every cycle and there are no stalls. A contiguous predicate that starts at lane 0 gives the same result as a left-pack, but in general kept bytes land at their own predicate positions.

Top module: `byte_expand_unit`

## Requirements
- R1: For a result lane k whose predicate bit is set, the result byte is source byte number popcount(pred & ((1<<k)-1)). Byte j of a vector is bits [8j+7:8j].
- R2: For a result lane whose predicate bit is clear, the read index is forced to 63, so the lane holds source byte 63.
- R3: An all-zero predicate yields a result in which every byte equals source byte 63.
- R4: A predicate set contiguously from lane 0 up to lane n-1 yields source bytes 0..n-1 in lanes 0..n-1 and the fill byte above them.
- R5: Every lane above the highest set predicate bit holds the fill byte. No kept lane reads a source index at or beyond the total number of set bits.
- R6: `out_valid` rises exactly two cycles after the cycle in which `in_valid` was presented. Inputs may arrive on every cycle, and every accepted input produces exactly one result, in order.
- R7: While reset is held and after it is released, `out_valid` is 0 and `out_vec` is all zero until the first result arrives.
- R8: `out_vec` keeps its last value in every cycle in which no new result is delivered.
- R9: An all-ones predicate returns the source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair on `in_src`/`in_pred` is valid this cycle |
| in_src | input | 512 | Packed source bytes, lane j at [8j+7:8j] |
| in_pred | input | 64 | Predicate, bit k governs result lane k |
| out_valid | output | 1 | `out_vec` carries a new result this cycle |
| out_vec | output | 512 | Expanded result, lane k at [8k+7:8k] |

## Verification
The bench targets the sparse predicate {3,7,9} and the stride-2 predicate, which catch a design that left-packs instead of expanding: such a design would put src[1] at lane 1 rather than lane 7. A single set bit at lane 63 catches an off-by-one in the prefix count, which would read src[1] or leave the fill. The all-zero and all-ones predicates catch a mistaken fill index and an inclusive count used where an exclusive one is needed; the inclusive count shifts every kept byte by one lane. A long back-to-back random stream exposes any lost, duplicated or late result, and an idle window after it exposes an output register that does not hold its value.

// File: rtl/bx_pkg.sv
// Shared defaults for the byte expand unit.
package bx_pkg;
    localparam int BX_LANES_DEF  = 64;   // byte lanes per vector
    localparam int BX_BYTE_W_DEF = 8;    // bits per lane
endpackage

// File: rtl/bx_prefix_count.sv
// Exclusive prefix population count of the predicate, built as a
// Hillis-Steele parallel-prefix adder tree of log2(LANES) levels.
// Assumes LANES is a power of two; the count below any lane is at most
// LANES-1, so IDX_W bits never overflow.
module bx_prefix_count #(
    parameter int LANES = bx_pkg::BX_LANES_DEF
) (
    input  logic [LANES-1:0]                 pred,
    output logic [LANES*$clog2(LANES)-1:0]   cnt_flat
);
    localparam int IDX_W = $clog2(LANES);
    localparam int LVLS  = $clog2(LANES);

    logic [IDX_W-1:0] lvl [LVLS+1][LANES];

    genvar i, l;
    generate
        // Level 0 holds each lane's lower neighbour bit (exclusive scan seed).
        for (i = 0; i < LANES; i++) begin : g_seed
            if (i == 0) begin : g_first
                assign lvl[0][0] = '0;
            end else begin : g_rest
                assign lvl[0][i] = {{(IDX_W-1){1'b0}}, pred[i-1]};
            end
        end
        // Each level adds the partial sum 2^l lanes below.
        for (l = 0; l < LVLS; l++) begin : g_lvl
            for (i = 0; i < LANES; i++) begin : g_node
                if (i >= (1 << l)) begin : g_add
                    assign lvl[l+1][i] = lvl[l][i] + lvl[l][i-(1<<l)];
                end else begin : g_pass
                    assign lvl[l+1][i] = lvl[l][i];
                end
            end
        end
        // Flatten the final level.
        for (i = 0; i < LANES; i++) begin : g_out
            assign cnt_flat[i*IDX_W +: IDX_W] = lvl[LVLS][i];
        end
    endgenerate
endmodule

// File: rtl/bx_lane_mux.sv
// Per-lane index clamp and byte multiplexer. A kept lane reads the source
// byte named by its prefix count; a dropped lane reads the top byte.
module bx_lane_mux #(
    parameter int LANES  = bx_pkg::BX_LANES_DEF,
    parameter int BYTE_W = bx_pkg::BX_BYTE_W_DEF
) (
    input  logic [LANES*BYTE_W-1:0]          src_vec,
    input  logic [LANES-1:0]                 pred,
    input  logic [LANES*$clog2(LANES)-1:0]   cnt_flat,
    output logic [LANES*BYTE_W-1:0]          res_vec
);
    localparam int IDX_W = $clog2(LANES);
    localparam logic [IDX_W-1:0] FILL_IDX = IDX_W'(LANES - 1);

    logic [BYTE_W-1:0] src_b [LANES];
    logic [IDX_W-1:0]  sel   [LANES];

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            // Unpack the source into addressable bytes.
            assign src_b[k] = src_vec[k*BYTE_W +: BYTE_W];
            // Clamp: dropped lanes are steered to the fill lane.
            assign sel[k] = pred[k] ? cnt_flat[k*IDX_W +: IDX_W] : FILL_IDX;
            // Byte mux for this result lane.
            assign res_vec[k*BYTE_W +: BYTE_W] = src_b[sel[k]];
        end
    endgenerate
endmodule

// File: rtl/byte_expand_unit.sv
// Two-stage predicate-driven byte expand. Stage 1 registers the operands
// and their exclusive prefix counts; stage 2 registers the muxed result.
// Assumes a synchronous active-low reset and LANES a power of two.
module byte_expand_unit #(
    parameter int LANES  = bx_pkg::BX_LANES_DEF,
    parameter int BYTE_W = bx_pkg::BX_BYTE_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [LANES*BYTE_W-1:0]   in_src,
    input  logic [LANES-1:0]          in_pred,
    output logic                      out_valid,
    output logic [LANES*BYTE_W-1:0]   out_vec
);
    localparam int IDX_W = $clog2(LANES);
    localparam int VEC_W = LANES * BYTE_W;

    logic [LANES*IDX_W-1:0] cnt_now;
    logic                   s1_valid;
    logic [VEC_W-1:0]       s1_src;
    logic [LANES-1:0]       s1_pred;
    logic [LANES*IDX_W-1:0] s1_cnt;
    logic [VEC_W-1:0]       mux_out;

    bx_prefix_count #(.LANES(LANES)) u_scan (
        .pred     (in_pred),
        .cnt_flat (cnt_now)
    );

    // Stage 1: capture operands and prefix counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_src   <= '0;
            s1_pred  <= '0;
            s1_cnt   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_src  <= in_src;
                s1_pred <= in_pred;
                s1_cnt  <= cnt_now;
            end
        end
    end

    bx_lane_mux #(.LANES(LANES), .BYTE_W(BYTE_W)) u_mux (
        .src_vec  (s1_src),
        .pred     (s1_pred),
        .cnt_flat (s1_cnt),
        .res_vec  (mux_out)
    );

    // Stage 2: register the result; hold it when nothing new arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_vec <= mux_out;
        end
    end
endmodule

// File: rtl/bx_expand_checker.sv
// Property checker for byte_expand_unit: keeps its own two-cycle shadow of
// the inputs and compares the outputs with a sequential reference count.
module bx_expand_checker #(
    parameter int LANES  = bx_pkg::BX_LANES_DEF,
    parameter int BYTE_W = bx_pkg::BX_BYTE_W_DEF
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [LANES*BYTE_W-1:0]   in_src,
    input logic [LANES-1:0]          in_pred,
    input logic                      out_valid,
    input logic [LANES*BYTE_W-1:0]   out_vec
);
    localparam int VEC_W = LANES * BYTE_W;

    logic             v1, v2, armed;
    logic [VEC_W-1:0] sh1, sh2, ref_vec;
    logic [LANES-1:0] ph1, ph2;
    logic             hi_fill_ok;
    logic [BYTE_W-1:0] top_b;

    // Shadow pipeline of the accepted inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; armed <= 1'b0;
            sh1 <= '0; sh2 <= '0; ph1 <= '0; ph2 <= '0;
        end else begin
            v1 <= in_valid; v2 <= v1; armed <= 1'b1;
            sh1 <= in_src;  sh2 <= sh1;
            ph1 <= in_pred; ph2 <= ph1;
        end
    end

    assign top_b = sh2[VEC_W-1 -: BYTE_W];

    // Reference result by a running count, plus the above-top-bit fill test.
    always_comb begin
        int n;
        int hi;
        n = 0;
        hi = -1;
        ref_vec = '0;
        hi_fill_ok = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (ph2[k]) begin
                ref_vec[k*BYTE_W +: BYTE_W] = sh2[n*BYTE_W +: BYTE_W];
                n = n + 1;
                hi = k;
            end else begin
                ref_vec[k*BYTE_W +: BYTE_W] = top_b;
            end
        end
        for (int k = 0; k < LANES; k++) begin
            if (k > hi && out_vec[k*BYTE_W +: BYTE_W] != top_b) hi_fill_ok = 1'b0;
        end
    end

    // R6: result strobe trails the input strobe by exactly two cycles.
    a_r6_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v2);

    // R1 and R2: kept lanes read the dense stream, dropped lanes the fill.
    a_r1_lane_values: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |-> out_vec == ref_vec);

    // R3: empty predicate fills every lane.
    a_r3_zero_pred_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && ph2 == '0) |-> out_vec == {LANES{top_b}});

    // R5: lanes above the highest kept lane hold the fill byte.
    a_r5_fill_above_top: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |-> hi_fill_ok);

    // R8: output holds while no result is delivered.
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !out_valid) |-> $stable(out_vec));
endmodule

bind byte_expand_unit bx_expand_checker #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_src    (in_src),
    .in_pred   (in_pred),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/sim_byte_expand_unit.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them when the unit delivers.
module sim_byte_expand_unit;
    localparam int LANES = 64;
    localparam int BW    = 8;
    localparam int VW    = LANES * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_src = '0;
    logic [63:0]   in_pred = '0;
    logic          out_valid;
    logic [VW-1:0] out_vec;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [VW-1:0] exp_q [$];
    int            due_q [$];
    string         tag_q [$];

    byte_expand_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_src(in_src), .in_pred(in_pred),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference expand by a running count of kept lanes.
    function automatic logic [VW-1:0] expand_ref(logic [VW-1:0] s, logic [63:0] p);
        logic [VW-1:0] r;
        int n;
        n = 0;
        r = '0;
        for (int k = 0; k < LANES; k++) begin
            if (p[k]) begin
                r[k*BW +: BW] = s[n*BW +: BW];
                n++;
            end else begin
                r[k*BW +: BW] = s[VW-1 -: BW];
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] ramp_src();
        logic [VW-1:0] s;
        for (int j = 0; j < LANES; j++) s[j*BW +: BW] = 8'(8'hA0 + j);
        return s;
    endfunction

    function automatic logic [VW-1:0] rand_src();
        logic [VW-1:0] s;
        for (int j = 0; j < VW/32; j++) s[j*32 +: 32] = $urandom;
        return s;
    endfunction

    task automatic check(input string req, input bit ok, input logic [VW-1:0] act,
                         input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present one operand pair and record its expected result.
    task automatic send(input logic [VW-1:0] s, input logic [63:0] p, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_src   = s;
        in_pred  = p;
        exp_q.push_back(expand_ref(s, p));
        due_q.push_back(cyc + 2);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each delivered result and its arrival cycle.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R6 spurious result", 1'b0, out_vec, '0);
            end else begin
                logic [VW-1:0] e;
                int d;
                string t;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                t = tag_q.pop_front();
                check(t, out_vec == e, out_vec, e);
                check("R6 latency", cyc == d, VW'(cyc), VW'(d));
            end
        end
    end

    initial begin
        logic [VW-1:0] ramp;
        logic [VW-1:0] held;
        ramp = ramp_src();

        repeat (3) @(negedge clk);
        check("R7 reset valid", out_valid == 1'b0, VW'(out_valid), '0);
        check("R7 reset data", out_vec == '0, out_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after release", out_valid == 1'b0 && out_vec == '0, out_vec, '0);

        send(ramp, 64'h0000_0000_0000_0288, "R1 sparse {3,7,9}");
        send(ramp, 64'h0000_0000_0000_0007, "R4 contiguous {0,1,2}");
        send(ramp, 64'h0000_0000_0000_0055, "R1 stride-2 {0,2,4,6}");
        send(ramp, 64'h0,                   "R3 zero predicate");
        send(ramp, {64{1'b1}},              "R9 all-ones identity");
        send(ramp, 64'h8000_0000_0000_0000, "R2 only lane 63");
        send(ramp, 64'h0000_0000_0000_0001, "R5 only lane 0");
        send(ramp, 64'h0000_0000_0000_FFFF, "R4 contiguous 16");
        send(ramp, 64'h0000_0000_0010_0400, "R5 fill above lane 20");
        for (int i = 0; i < 40; i++) begin
            send(rand_src(), {$urandom, $urandom}, "R1 random back-to-back");
        end
        idle();

        wait (exp_q.size() == 0);
        @(negedge clk);
        held = out_vec;
        repeat (4) begin
            @(negedge clk);
            check("R8 hold when idle", !out_valid && out_vec == held, out_vec, held);
        end

        send(rand_src(), 64'h0, "R3 zero predicate random");
        idle();
        send(rand_src(), 64'hF0F0_0000_0000_00FF, "R2 mixed gaps");
        idle();
        repeat (5) @(negedge clk);
        check("R6 all results delivered", exp_q.size() == 0, VW'(exp_q.size()), '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule